// File: doc/BRIEF.md
# Multi-Port GPIO Controller with Edge Interrupts

This block is a register-mapped general-purpose I/O controller. Its pins are grouped into ports of eight, and the number of ports is a build parameter. Each port has its own bank of registers: output data, a read-only input level, a two-bit drive mode per pin, a pull-up disable mask, and an interrupt group of event, enable, force and edge-select bits. Each port raises one interrupt line that covers its eight pins.

Software reaches the registers over a simple single-cycle bus. A write takes effect on the clock edge where the write enable is high. Read data is combinational from the address. A global control word at byte address 0x00 holds a run enable for the interrupt logic and a select for the input synchroniser. The same word also reads back the port count and a version number. Pin n belongs to port n/8, and port p's bank starts at byte address 0x30*p.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every writable register of every port reads 0. pin_oe is all 0, port_irq is all 0 and pull_en is all 1.
- R2: The control word at address 0x00 has a run enable at bit 0 and a synchroniser select at bit 1, and both are read/write. Bits 15:9 read the port count and bits 8:2 read the version ID. Writes to these read-only fields are ignored, and all other bits read 0.
- R3: Port p's bank starts at byte 0x30*p. Its offsets are: input level 0x04, output data 0x08, drive mode 0x0C, pull-up disable 0x10, event 0x14, enable 0x18, force 0x1C, edge select 0x20. A write to one port leaves the other ports unchanged. The input level register ignores writes, and an unmapped offset reads 0.
- R4: The drive mode of pin k sits at bits [2k+1:2k] of the mode register. The codes are:
  - 00 input: output disabled, drives 0.
  - 01 push-pull: output enabled, drives the data bit.
  - 10 open-drain: output enabled only when the data bit is 0, always drives 0.
  - 11 open-source: output enabled only when the data bit is 1, always drives 1.
- R5: A set bit in a port's pull-up disable register clears the matching bit of pull_en.
- R6: With the synchroniser select at 0, the input level register shows pin_in directly. With it at 1, a change on pin_in reaches the register two clock edges later.
- R7: An edge-select bit of 1 sets the pin's event bit on a rising edge of its input level, and 0 sets it on a falling edge. The other edge direction leaves the event bit unchanged.
- R8: Event bits stay set until software writes 1 to them. Writing 0 to an event bit has no effect.
- R9: While a force bit is set and the run enable is 1, the matching event bit is set as if its edge had occurred.
- R10: port_irq[p] is high exactly when port p has at least one pin whose event and enable bits are both set.
- R11: While the run enable is 0, no event bit becomes set, but registers stay readable and writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 8*NUM_PORTS | Pin input levels |
| pin_out | output | 8*NUM_PORTS | Pin output values |
| pin_oe | output | 8*NUM_PORTS | Pin output enables |
| pull_en | output | 8*NUM_PORTS | Pull-up enables, one per pin |
| port_irq | output | NUM_PORTS | One interrupt per port |

## Verification
The bench runs each drive mode with both data values. A design that swaps the open-drain and open-source enables, or leaves the output enabled in input mode, shows a wrong pin_oe pattern. It applies edges in both directions to pins set to the opposite sense, which catches an inverted edge select or a detector that fires on any toggle. It writes zero to set event bits, writes to one port's bank, and writes to the read-only control fields. A clear that ignores the written mask, an address decode with the wrong stride, or control fields that can be overwritten each show up as a changed read-back. It samples the synchronised input after one edge and after two, and it forces an event while the run enable is off. A synchroniser one stage short, or a force that bypasses the run enable, gives a different value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PINS_PER_PORT = 8;
    localparam int BANK_STRIDE   = 48;
    localparam int MODE_BITS     = 2;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_LEVEL,
        SEL_DOUT,
        SEL_MODE,
        SEL_PUD,
        SEL_EVT,
        SEL_EN,
        SEL_FRC,
        SEL_EDGE
    } reg_sel_e;

    typedef enum logic [1:0] {
        DRV_INPUT       = 2'b00,
        DRV_PUSH_PULL   = 2'b01,
        DRV_OPEN_DRAIN  = 2'b10,
        DRV_OPEN_SOURCE = 2'b11
    } drive_mode_e;

    typedef struct packed {
        logic out;
        logic oe;
    } pad_drive_t;

    typedef struct packed {
        logic [PINS_PER_PORT-1:0]           dout;
        logic [MODE_BITS*PINS_PER_PORT-1:0] mode;
        logic [PINS_PER_PORT-1:0]           pud;
        logic [PINS_PER_PORT-1:0]           evt;
        logic [PINS_PER_PORT-1:0]           en;
        logic [PINS_PER_PORT-1:0]           frc;
        logic [PINS_PER_PORT-1:0]           edge_sel;
    } port_regs_t;

    // Offset inside one port's bank to register selector
    function automatic reg_sel_e decode_offset(input logic [5:0] off);
        case (off)
            6'h04:   return SEL_LEVEL;
            6'h08:   return SEL_DOUT;
            6'h0C:   return SEL_MODE;
            6'h10:   return SEL_PUD;
            6'h14:   return SEL_EVT;
            6'h18:   return SEL_EN;
            6'h1C:   return SEL_FRC;
            6'h20:   return SEL_EDGE;
            default: return SEL_NONE;
        endcase
    endfunction

    // Pad drive for one pin from its mode and data bit
    function automatic pad_drive_t drive_pin(input drive_mode_e m, input logic d);
        pad_drive_t r;
        case (m)
            DRV_PUSH_PULL:   begin r.out = d;    r.oe = 1'b1; end
            DRV_OPEN_DRAIN:  begin r.out = 1'b0; r.oe = ~d;   end
            DRV_OPEN_SOURCE: begin r.out = 1'b1; r.oe = d;    end
            default:         begin r.out = 1'b0; r.oe = 1'b0; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect
    import gpio_pkg::*;
#(
    parameter int W = PINS_PER_PORT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] raw,
    input  logic         sync_sel,
    input  logic [W-1:0] edge_sel,
    output logic [W-1:0] level,
    output logic [W-1:0] hit
);
    logic [W-1:0] stage1, stage2, prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
            prev   <= '0;
        end else begin
            stage1 <= raw;
            stage2 <= stage1;
            prev   <= level;
        end
    end

    assign level = sync_sel ? stage2 : raw;

    // 1 = rising, 0 = falling
    assign hit = (edge_sel & level & ~prev) | (~edge_sel & ~level & prev);

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_pkg::*;
#(
    parameter int W = PINS_PER_PORT
) (
    input  logic [MODE_BITS*W-1:0] mode,
    input  logic [W-1:0]           dout,
    output logic [W-1:0]           out,
    output logic [W-1:0]           oe
);
    for (genvar k = 0; k < W; k++) begin : g_pin
        pad_drive_t d;
        assign d      = drive_pin(drive_mode_e'(mode[MODE_BITS*k +: MODE_BITS]), dout[k]);
        assign out[k] = d.out;
        assign oe[k]  = d.oe;
    end

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  reg_sel_e                 sel,
    input  logic [15:0]              wdata,
    input  logic [PINS_PER_PORT-1:0] level,
    input  logic [PINS_PER_PORT-1:0] hit,
    input  logic                     run_en,
    output port_regs_t               regs,
    output logic [31:0]              rdata,
    output logic                     irq
);
    logic [PINS_PER_PORT-1:0] evt_clr, evt_set, evt_next;

    assign evt_clr  = (wr_en && sel == SEL_EVT) ? wdata[PINS_PER_PORT-1:0] : '0;
    assign evt_set  = run_en ? (hit | regs.frc) : '0;
    // a new event wins over a clear in the same cycle
    assign evt_next = (regs.evt & ~evt_clr) | evt_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            regs.evt <= evt_next;
            if (wr_en) begin
                case (sel)
                    SEL_DOUT: regs.dout     <= wdata[PINS_PER_PORT-1:0];
                    SEL_MODE: regs.mode     <= wdata;
                    SEL_PUD:  regs.pud      <= wdata[PINS_PER_PORT-1:0];
                    SEL_EN:   regs.en       <= wdata[PINS_PER_PORT-1:0];
                    SEL_FRC:  regs.frc      <= wdata[PINS_PER_PORT-1:0];
                    SEL_EDGE: regs.edge_sel <= wdata[PINS_PER_PORT-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (sel)
            SEL_LEVEL: rdata[PINS_PER_PORT-1:0] = level;
            SEL_DOUT:  rdata[PINS_PER_PORT-1:0] = regs.dout;
            SEL_MODE:  rdata[15:0]              = regs.mode;
            SEL_PUD:   rdata[PINS_PER_PORT-1:0] = regs.pud;
            SEL_EVT:   rdata[PINS_PER_PORT-1:0] = regs.evt;
            SEL_EN:    rdata[PINS_PER_PORT-1:0] = regs.en;
            SEL_FRC:   rdata[PINS_PER_PORT-1:0] = regs.frc;
            SEL_EDGE:  rdata[PINS_PER_PORT-1:0] = regs.edge_sel;
            default:   rdata = '0;
        endcase
    end

    assign irq = |(regs.evt & regs.en);

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int          NUM_PORTS  = 3,
    parameter int          ADDR_W     = 12,
    parameter logic [6:0]  VERSION_ID = 7'd3,
    localparam int         NPINS      = NUM_PORTS * PINS_PER_PORT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pull_en,
    output logic [NUM_PORTS-1:0] port_irq
);
    logic ctrl_run_en, ctrl_sync_sel;
    logic [ADDR_W-1:0] bank_idx, bank_off;
    logic              is_ctrl;
    reg_sel_e          sel;
    logic [NPINS-1:0]  evt_all, en_all, frc_all;
    logic [31:0]       port_rd [NUM_PORTS];
    logic              unused_bits;

    assign bank_idx    = bus_addr / ADDR_W'(BANK_STRIDE);
    assign bank_off    = bus_addr % ADDR_W'(BANK_STRIDE);
    assign is_ctrl     = (bus_addr == '0);
    assign sel         = decode_offset(bank_off[5:0]);
    assign unused_bits = ^{bus_wdata[31:16], bank_off[ADDR_W-1:6]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_run_en   <= 1'b0;
            ctrl_sync_sel <= 1'b0;
        end else if (bus_we && is_ctrl) begin
            ctrl_run_en   <= bus_wdata[0];
            ctrl_sync_sel <= bus_wdata[1];
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        port_regs_t               regs;
        logic [PINS_PER_PORT-1:0] level, hit;
        logic                     hit_bank;

        assign hit_bank = (bank_idx == ADDR_W'(p)) && !is_ctrl;

        gpio_edge_detect #(.W(PINS_PER_PORT)) u_edge (
            .clk      (clk),
            .rst      (rst),
            .raw      (pin_in[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .sync_sel (ctrl_sync_sel),
            .edge_sel (regs.edge_sel),
            .level    (level),
            .hit      (hit)
        );

        gpio_port_bank u_bank (
            .clk    (clk),
            .rst    (rst),
            .wr_en  (bus_we && hit_bank),
            .sel    (sel),
            .wdata  (bus_wdata[15:0]),
            .level  (level),
            .hit    (hit),
            .run_en (ctrl_run_en),
            .regs   (regs),
            .rdata  (port_rd[p]),
            .irq    (port_irq[p])
        );

        gpio_pad_drive #(.W(PINS_PER_PORT)) u_pad (
            .mode (regs.mode),
            .dout (regs.dout),
            .out  (pin_out[p*PINS_PER_PORT +: PINS_PER_PORT]),
            .oe   (pin_oe[p*PINS_PER_PORT +: PINS_PER_PORT])
        );

        assign pull_en[p*PINS_PER_PORT +: PINS_PER_PORT] = ~regs.pud;
        assign evt_all[p*PINS_PER_PORT +: PINS_PER_PORT] = regs.evt;
        assign en_all [p*PINS_PER_PORT +: PINS_PER_PORT] = regs.en;
        assign frc_all[p*PINS_PER_PORT +: PINS_PER_PORT] = regs.frc;
    end

    always_comb begin
        bus_rdata = '0;
        if (is_ctrl) begin
            bus_rdata[15:9] = 7'(NUM_PORTS);
            bus_rdata[8:2]  = VERSION_ID;
            bus_rdata[1]    = ctrl_sync_sel;
            bus_rdata[0]    = ctrl_run_en;
        end else begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (bank_idx == ADDR_W'(p)) bus_rdata = port_rd[p];
            end
        end
    end

endmodule

// File: rtl/gpio_ctrl_checker.sv
module gpio_ctrl_checker #(
    parameter int NUM_PORTS = 3,
    localparam int NPINS    = NUM_PORTS * 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 bus_we,
    input logic                 run_en,
    input logic [NPINS-1:0]     evt_all,
    input logic [NPINS-1:0]     en_all,
    input logic [NPINS-1:0]     frc_all,
    input logic [NUM_PORTS-1:0] port_irq,
    input logic [NPINS-1:0]     pin_oe,
    input logic [NPINS-1:0]     pull_en
);
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pin_oe == '0 && port_irq == '0 && pull_en == '1));

    assert_freeze_no_set_R11: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> ((evt_all & ~$past(evt_all)) == '0));

    assert_event_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> (($past(evt_all) & ~evt_all) == '0));

    assert_force_sets_R9: assert property (@(posedge clk) disable iff (rst)
        (run_en && frc_all != '0) |=> ((evt_all & $past(frc_all)) == $past(frc_all)));

    assert_irq_needs_enabled_event_R10: assert property (@(posedge clk) disable iff (rst)
        ((evt_all & en_all) == '0) |-> (port_irq == '0));

endmodule

bind gpio_port_ctrl gpio_ctrl_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .run_en   (ctrl_run_en),
    .evt_all  (evt_all),
    .en_all   (en_all),
    .frc_all  (frc_all),
    .port_irq (port_irq),
    .pin_oe   (pin_oe),
    .pull_en  (pull_en)
);

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP         = 3;
    localparam int AW         = 12;
    localparam int NPIN       = NP * 8;
    localparam logic [31:0] CTRL_RO = (32'(NP) << 9) | (32'd3 << 2);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [AW-1:0]   bus_addr = '0;
    logic            bus_we = 1'b0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NPIN-1:0] pin_in = '0;
    logic [NPIN-1:0] pin_out, pin_oe, pull_en;
    logic [NP-1:0]   port_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ctrl #(.NUM_PORTS(NP), .ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en), .port_irq(port_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_addr = AW'(addr); bus_wdata = data; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        @(negedge clk);
        bus_addr = AW'(addr);
        #1 data = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        for (int p = 0; p < NP; p++) begin
            for (int off = 8; off <= 32; off += 4) begin
                rd(p*48 + off, v);
                check("R1 register zero after reset", v, 32'h0);
            end
        end
        check("R1 pin_oe", 32'(pin_oe), 32'h0);
        check("R1 port_irq", 32'(port_irq), 32'h0);
        check("R1 pull_en", 32'(pull_en), 32'(24'hFFFFFF));
    endtask

    task automatic t_ctrl;
        logic [31:0] v;
        rd(0, v);  check("R2 control read-only fields", v, CTRL_RO);
        wr(0, 32'hFFFF_FFFF);
        rd(0, v);  check("R2 control write all ones", v, CTRL_RO | 32'h3);
        wr(0, 32'h1);
        rd(0, v);  check("R2 run enable only", v, CTRL_RO | 32'h1);
    endtask

    task automatic t_map;
        logic [31:0] v;
        wr(48 + 8, 32'hA5);
        wr(96 + 8, 32'h3C);
        wr(48 + 4, 32'hFF);
        rd(8, v);       check("R3 port0 output data untouched", v, 32'h00);
        rd(48 + 8, v);  check("R3 port1 output data", v, 32'hA5);
        rd(96 + 8, v);  check("R3 port2 output data", v, 32'h3C);
        rd(48 + 4, v);  check("R3 input level ignores write", v, 32'h00);
        rd(48, v);      check("R3 unmapped offset", v, 32'h00);
        wr(48 + 8, 32'h0);
        wr(96 + 8, 32'h0);
    endtask

    task automatic t_drive;
        // pin0 input, pin1 push-pull, pin2 open-drain, pin3 open-source
        wr(12, 32'h00E4);
        wr(8, 32'h0F);
        check("R4 oe with data 1", 32'(pin_oe[3:0]), 32'hA);
        check("R4 out with data 1", 32'(pin_out[3:0]), 32'hA);
        wr(8, 32'h00);
        check("R4 oe with data 0", 32'(pin_oe[3:0]), 32'h6);
        check("R4 out with data 0", 32'(pin_out[3:0]), 32'h8);
        wr(12, 32'h0);
        check("R4 input mode oe", 32'(pin_oe), 32'h0);
    endtask

    task automatic t_pull;
        wr(96 + 16, 32'h81);
        check("R5 pull_en after disable", 32'(pull_en), 32'h7EFFFF);
        wr(96 + 16, 32'h00);
    endtask

    task automatic t_edges;
        logic [31:0] v;
        wr(32, 32'h01);            // pin0 rising, pin1 falling
        @(negedge clk); pin_in[0] = 1'b1; pin_in[1] = 1'b1;
        rd(20, v); check("R7 rising edge on rising-select only", v, 32'h01);
        @(negedge clk); pin_in[1] = 1'b0;
        rd(20, v); check("R7 falling edge sets falling-select pin", v, 32'h03);
        @(negedge clk); pin_in[0] = 1'b0;
        rd(20, v); check("R7 falling edge ignored on rising-select", v, 32'h03);
        check("R10 no irq while disabled", 32'(port_irq), 32'h0);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(20, 32'h01);
        rd(20, v); check("R8 write one clears only that bit", v, 32'h02);
        wr(20, 32'h00);
        rd(20, v); check("R8 write zero keeps events", v, 32'h02);
        wr(20, 32'h02);
        rd(20, v); check("R8 clear last event", v, 32'h00);
    endtask

    task automatic t_force_irq;
        logic [31:0] v;
        wr(48 + 28, 32'h10);
        wr(48 + 28, 32'h00);
        rd(48 + 20, v); check("R9 forced event stays set", v, 32'h10);
        check("R10 irq low with enable 0", 32'(port_irq), 32'h0);
        wr(48 + 24, 32'h10);
        check("R10 irq on port1 only", 32'(port_irq), 32'h2);
        wr(48 + 24, 32'hEF);
        check("R10 irq low with other enables", 32'(port_irq), 32'h0);
        wr(48 + 24, 32'h10);
        wr(48 + 20, 32'h10);
        check("R10 irq drops after clear", 32'(port_irq), 32'h0);
        wr(48 + 24, 32'h00);
    endtask

    task automatic t_freeze;
        logic [31:0] v;
        wr(0, 32'h0);
        wr(96 + 28, 32'h01);
        idle(3);
        rd(96 + 20, v); check("R11 no event while frozen", v, 32'h00);
        rd(96 + 28, v); check("R11 register writable while frozen", v, 32'h01);
        wr(0, 32'h1);
        rd(96 + 20, v); check("R11 event after run enable", v, 32'h01);
        wr(96 + 28, 32'h00);
        wr(96 + 20, 32'h01);
    endtask

    task automatic t_sync;
        wr(0, 32'h3);
        @(negedge clk);
        bus_addr = AW'(48 + 4);
        pin_in[8] = 1'b1;
        @(posedge clk); #1;
        check("R6 synchronised level after one edge", bus_rdata, 32'h00);
        @(posedge clk); #1;
        check("R6 synchronised level after two edges", bus_rdata, 32'h01);
        wr(0, 32'h1);
        @(negedge clk);
        bus_addr = AW'(48 + 4);
        pin_in[9] = 1'b1;
        #1 check("R6 direct level without synchroniser", bus_rdata, 32'h03);
    endtask

    initial begin
        idle(3);
        rst = 1'b0;
        t_reset();
        t_ctrl();
        t_map();
        t_drive();
        t_pull();
        t_edges();
        t_w1c();
        t_force_irq();
        t_freeze();
        t_sync();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule